// File: doc/BRIEF.md
# Status and Write-Protect Gate

This block decides, one write request at a time, whether a small clock-plus-memory device may accept a byte. A serial bus front end hands it a decoded request: a target space, an address and a data byte, qualified by a strobe. One cycle later the block answers with either an accept pulse or a reject pulse, and the bus layer acknowledges or withholds the acknowledge on that basis. The memory array, the timekeeping counters and the bus engine stay outside. The block only gates writes, provides a status byte for readback and drives a run enable for the clock counters.

Three pieces of state shape every decision. The first is a volatile write-enable latch, which moves only on two exact status byte patterns. The second is a sticky power-fail flag, which is set by a total-loss reset and holds the clock stopped until a clock write is accepted. The third is a three-bit protection code, which selects one of eight address ranges of the array where writes are dropped. Array and control writes start a nonvolatile programming window, and every request that arrives during that window is rejected. Status and clock writes start no such window, so the block is ready again at once.

Top module: `sr_write_gate`

## Requirements
- R1: `rst_cold` (total supply loss) clears the enable latch, sets the power-fail flag, sets the protection code to 0 and drives `clk_run` low. `rst_warm` (supply-backed power-up) clears the enable latch and the busy window, and leaves the power-fail flag and the protection code unchanged.
- R2: While the enable latch is clear, every request to the clock space (`wr_space`=01), the control space (10) or the array space (00) is rejected and changes no state.
- R3: A status-space (11) write with data 0x02 sets the enable latch. A status-space write with data 0x00 clears it. Any other status data is rejected and changes nothing. Status writes are accepted whether or not the latch is set.
- R4: `status_byte` shows the power-fail flag in bit 0 and the enable latch in bit 1. Bits 2 to 7, and so the unused bits 3 and 4, always read 0.
- R5: The power-fail flag is read-only. No status write changes bit 0.
- R6: An accepted clock write clears the power-fail flag. `clk_run` rises one cycle after that accept pulse. While the flag is set, `clk_run` stays low.
- R7: Protection code to protected range, with array depth D=512 and page size P=64: 0 gives no protection (`prot_none`=1). 1 gives [3D/4, D-1]. 2 gives [D/2, D-1]. 3 gives [0, D-1]. Codes 4, 5, 6 and 7 give [0, n*P-1] for n = 1, 2, 4 and 8, with the end clamped to D-1.
- R8: An array write is accepted only when the latch is set, the address is below D and the address lies outside the protected range.
- R9: An accepted control write loads the protection code from data bits [2:0].
- R10: An accepted array or control write holds `busy` high for NV_CYCLES (16) cycles, starting the cycle after the request. Every request made while `busy` is high is rejected. Accepted status and clock writes leave `busy` low.
- R11: Each request gives exactly one of `wr_ack` and `wr_nack`, as a one-cycle pulse in the cycle after the request. Neither pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Synchronous reset after total supply loss |
| rst_warm | input | 1 | Synchronous reset after supply-backed power-up |
| wr_req | input | 1 | Write request strobe |
| wr_space | input | 2 | Target: 00 array, 01 clock, 10 control, 11 status |
| wr_addr | input | ADDR_W (10) | Array byte address |
| wr_data | input | 8 | Write data byte |
| wr_ack | output | 1 | Request accepted (registered pulse) |
| wr_nack | output | 1 | Request rejected (registered pulse) |
| busy | output | 1 | Nonvolatile programming window active |
| status_byte | output | 8 | Status readback |
| prot_code | output | 3 | Current protection code |
| prot_none | output | 1 | No address is protected |
| prot_lo | output | ADDR_W (10) | First protected address |
| prot_hi | output | ADDR_W (10) | Last protected address |
| clk_run | output | 1 | Run enable for the clock counters |

## Verification
The hardest state to reach from the ports is an array write at the exact edge of a protected range, with the latch set and no programming window open. Each accepted probe opens a new window, and the window would hide the protection result behind a busy reject. The stimulus therefore unlocks the latch, releases the power-fail flag with a clock write, and then steps through all eight protection codes. At each code it probes the addresses on both sides of every range boundary, and it idles past the window after each probe. A behavioural model tracks the latch, the flag, the code and the window counter on every cycle. It also confirms the case where a request lands inside an open window.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    SP_ARRAY  = 2'b00,
    SP_CLOCK  = 2'b01,
    SP_CTRL   = 2'b10,
    SP_STATUS = 2'b11
  } space_e;

  localparam int unsigned ST_PF_BIT  = 0;
  localparam int unsigned ST_WEN_BIT = 1;

  localparam logic [7:0] WEN_SET_PATTERN = 8'h02;
  localparam logic [7:0] WEN_CLR_PATTERN = 8'h00;
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned PAGE   = 64,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              none,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] Q3_A   = ADDR_W'((DEPTH * 3) / 4);
  localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(DEPTH / 2);

  logic [ADDR_W-1:0] pg_end [4];

  for (genvar g = 0; g < 4; g++) begin : g_pages
    localparam int unsigned RAW = PAGE << g;
    localparam int unsigned CAP = (RAW > DEPTH) ? DEPTH : RAW;
    assign pg_end[g] = ADDR_W'(CAP - 1);
  end

  always_comb begin
    none = 1'b0;
    lo   = '0;
    hi   = '0;
    case (code)
      3'd0: none = 1'b1;
      3'd1: begin lo = Q3_A;   hi = LAST_A; end
      3'd2: begin lo = HALF_A; hi = LAST_A; end
      3'd3: begin lo = '0;     hi = LAST_A; end
      default: begin
        lo = '0;
        hi = pg_end[code[1:0]];
      end
    endcase
  end

  assign hit = !none && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/sr_nv_timer.sv
module sr_nv_timer #(
  parameter int unsigned NV_CYCLES = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(NV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(NV_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)                cnt <= '0;
    else if (start)         cnt <= LOAD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (clr)
    start |=> busy); // R10
endmodule

// File: rtl/sr_status_regs.sv
module sr_status_regs (
  input  logic       clk,
  input  logic       rst_cold,
  input  logic       rst_warm,
  input  logic       set_wen,
  input  logic       clr_wen,
  input  logic       clear_pf,
  input  logic       code_we,
  input  logic [2:0] code_in,
  output logic       wen,
  output logic       pf,
  output logic [2:0] code,
  output logic       clk_run
);
  always_ff @(posedge clk) begin
    if (rst_cold || rst_warm) wen <= 1'b0;
    else if (set_wen)         wen <= 1'b1;
    else if (clr_wen)         wen <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_cold)      pf <= 1'b1;
    else if (clear_pf) pf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_cold)     code <= '0;
    else if (code_we) code <= code_in;
  end

  always_ff @(posedge clk) begin
    if (rst_cold) clk_run <= 1'b0;
    else          clk_run <= !pf;
  end

  AST_WEN_RISE_ON_SET: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    $rose(wen) |-> $past(set_wen)); // R3
  AST_PF_FALL_ON_CLOCK: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    $fell(pf) |-> $past(clear_pf)); // R6
endmodule

// File: rtl/sr_write_gate.sv
module sr_write_gate
  import sr_pkg::*;
#(
  parameter int unsigned DEPTH     = 512,
  parameter int unsigned PAGE      = 64,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_cold,
  input  logic              rst_warm,
  input  logic              wr_req,
  input  logic [1:0]        wr_space,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wr_ack,
  output logic              wr_nack,
  output logic              busy,
  output logic [7:0]        status_byte,
  output logic [2:0]        prot_code,
  output logic              prot_none,
  output logic [ADDR_W-1:0] prot_lo,
  output logic [ADDR_W-1:0] prot_hi,
  output logic              clk_run
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(DEPTH);

  space_e sp;
  logic   wen, pf, hit, in_array, pat_set, pat_clr, accept;
  logic   set_wen, clr_wen, clear_pf, code_we, nv_start;

  assign sp       = space_e'(wr_space);
  assign in_array = ({1'b0, wr_addr} < DEPTH_V);
  assign pat_set  = (wr_data == WEN_SET_PATTERN);
  assign pat_clr  = (wr_data == WEN_CLR_PATTERN);

  sr_prot_decode #(.DEPTH(DEPTH), .PAGE(PAGE), .ADDR_W(ADDR_W)) u_prot (
    .code (prot_code),
    .addr (wr_addr),
    .none (prot_none),
    .lo   (prot_lo),
    .hi   (prot_hi),
    .hit  (hit)
  );

  always_comb begin
    case (sp)
      SP_STATUS: accept = pat_set || pat_clr;
      SP_CLOCK:  accept = wen;
      SP_CTRL:   accept = wen;
      default:   accept = wen && in_array && !hit;
    endcase
    if (busy) accept = 1'b0;
  end

  assign set_wen  = wr_req && accept && (sp == SP_STATUS) && pat_set;
  assign clr_wen  = wr_req && accept && (sp == SP_STATUS) && pat_clr;
  assign clear_pf = wr_req && accept && (sp == SP_CLOCK);
  assign code_we  = wr_req && accept && (sp == SP_CTRL);
  assign nv_start = wr_req && accept && ((sp == SP_ARRAY) || (sp == SP_CTRL));

  sr_status_regs u_regs (
    .clk      (clk),
    .rst_cold (rst_cold),
    .rst_warm (rst_warm),
    .set_wen  (set_wen),
    .clr_wen  (clr_wen),
    .clear_pf (clear_pf),
    .code_we  (code_we),
    .code_in  (wr_data[2:0]),
    .wen      (wen),
    .pf       (pf),
    .code     (prot_code),
    .clk_run  (clk_run)
  );

  sr_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_nv (
    .clk   (clk),
    .clr   (rst_cold || rst_warm),
    .start (nv_start),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst_cold || rst_warm) begin
      wr_ack  <= 1'b0;
      wr_nack <= 1'b0;
    end else begin
      wr_ack  <= wr_req && accept;
      wr_nack <= wr_req && !accept;
    end
  end

  always_comb begin
    status_byte             = '0;
    status_byte[ST_PF_BIT]  = pf;
    status_byte[ST_WEN_BIT] = wen;
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    !(wr_ack && wr_nack)); // R11
  AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    (wr_ack || wr_nack) |-> $past(wr_req)); // R11
  AST_NO_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    wr_ack |-> $past(!busy)); // R10
  AST_LOCKED_REJECT: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    (wr_req && !wen && (sp != SP_STATUS)) |=> wr_nack); // R2
  AST_CLOCK_RELEASE: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    $rose(clk_run) |-> $past(wr_ack)); // R6
endmodule

// File: tb/tb_sr_write_gate.sv
module tb_sr_write_gate;
  localparam int D  = 512;
  localparam int P  = 64;
  localparam int AW = 10;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_cold = 1'b1, rst_warm = 1'b0;
  logic wr_req = 1'b0;
  logic [1:0] wr_space = 2'b00;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ack, wr_nack, busy, prot_none, clk_run;
  logic [7:0] status_byte;
  logic [2:0] prot_code;
  logic [AW-1:0] prot_lo, prot_hi;

  int total = 0, bad = 0, cyc = 0;
  bit started = 0;

  always #4 clk = ~clk;

  sr_write_gate #(.DEPTH(D), .PAGE(P), .ADDR_W(AW), .NV_CYCLES(NV)) dut (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .wr_req(wr_req),
    .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_nack(wr_nack), .busy(busy), .status_byte(status_byte),
    .prot_code(prot_code), .prot_none(prot_none), .prot_lo(prot_lo),
    .prot_hi(prot_hi), .clk_run(clk_run)
  );

  // behavioural reference state
  int m_wen = 0, m_pf = 1, m_code = 0, m_cnt = 0, m_ack = 0, m_nack = 0, m_run = 0;

  function automatic void range_of(input int c, output int none, output int lo, output int hi);
    none = 0; lo = 0; hi = 0;
    if (c == 0) none = 1;
    else if (c == 1) begin lo = 3 * D / 4; hi = D - 1; end
    else if (c == 2) begin lo = D / 2; hi = D - 1; end
    else if (c == 3) hi = D - 1;
    else begin
      hi = P * (1 << (c - 4));
      if (hi > D) hi = D;
      hi = hi - 1;
    end
  endfunction

  always @(posedge clk) begin
    int acc, none, lo, hi, a, dv;
    started <= 1;
    if (rst_cold) begin
      m_wen = 0; m_pf = 1; m_code = 0; m_cnt = 0; m_ack = 0; m_nack = 0; m_run = 0;
    end else begin
      m_run = (m_pf == 0);
      if (rst_warm) begin
        m_wen = 0; m_cnt = 0; m_ack = 0; m_nack = 0;
      end else begin
        a = int'(wr_addr); dv = int'(wr_data);
        range_of(m_code, none, lo, hi);
        case (int'(wr_space))
          3: acc = (dv == 2 || dv == 0);
          1: acc = m_wen;
          2: acc = m_wen;
          default: acc = (m_wen != 0 && a < D && (none != 0 || a < lo || a > hi));
        endcase
        if (m_cnt > 0) acc = 0;
        m_ack = (wr_req && acc != 0); m_nack = (wr_req && acc == 0);
        if (m_ack != 0) begin
          case (int'(wr_space))
            3: m_wen = (dv == 2);
            1: m_pf = 0;
            2: begin m_code = dv % 8; m_cnt = NV; end
            default: m_cnt = NV;
          endcase
          if (int'(wr_space) == 1 || int'(wr_space) == 3) begin
            if (m_cnt > 0) m_cnt--;
          end
        end else if (m_cnt > 0) m_cnt--;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int none, lo, hi;
    if (started) begin
      range_of(m_code, none, lo, hi);
      check("R11 wr_ack", int'(wr_ack), m_ack);
      check("R11 wr_nack", int'(wr_nack), m_nack);
      check("R3 status_byte", int'(status_byte), m_pf + 2 * m_wen);
      check("R6 clk_run", int'(clk_run), m_run);
      check("R10 busy", int'(busy), int'(m_cnt > 0));
      check("R9 prot_code", int'(prot_code), m_code);
      check("R7 prot_none", int'(prot_none), none);
      if (none == 0) begin
        check("R7 prot_lo", int'(prot_lo), lo);
        check("R7 prot_hi", int'(prot_hi), hi);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_wr(input int sp, input int addr, input int data);
    @(negedge clk);
    wr_req = 1'b1; wr_space = 2'(sp); wr_addr = AW'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_reset(input bit cold);
    @(negedge clk);
    if (cold) rst_cold = 1'b1; else rst_warm = 1'b1;
    idle(3);
    rst_cold = 1'b0; rst_warm = 1'b0;
    idle(1);
  endtask

  int probes[11] = '{0, 63, 64, 127, 128, 255, 256, 383, 384, 511, 512};

  initial begin
    idle(3);
    rst_cold = 1'b0;
    idle(1);
    check("R1 cold status", int'(status_byte), 8'h01);
    check("R1 cold clk_run", int'(clk_run), 0);
    check("R1 cold code", int'(prot_code), 0);

    do_wr(0, 16, 8'hAA); check("R2 array locked", int'(wr_nack), 1);
    do_wr(1, 0, 8'h11);  check("R2 clock locked", int'(wr_nack), 1);
    do_wr(2, 0, 8'h01);  check("R2 control locked", int'(wr_nack), 1);
    check("R2 code kept", int'(prot_code), 0);

    do_wr(3, 0, 8'h06); check("R3 bad pattern", int'(wr_nack), 1);
    do_wr(3, 0, 8'h02); check("R3 set pattern", int'(wr_ack), 1);
    check("R3 latch set", int'(status_byte), 8'h03);
    check("R4 unused bits", int'(status_byte[7:2]), 0);
    do_wr(3, 0, 8'h03); check("R5 pf write rejected", int'(wr_nack), 1);
    check("R5 pf unchanged", int'(status_byte[0]), 1);
    do_wr(3, 0, 8'h18); check("R4 unused bits write", int'(wr_nack), 1);
    check("R4 unused bits stay 0", int'(status_byte[4:3]), 0);

    do_wr(1, 0, 8'h30); check("R6 clock ack", int'(wr_ack), 1);
    check("R6 clk_run lags", int'(clk_run), 0);
    idle(1);
    check("R6 clk_run up", int'(clk_run), 1);
    check("R6 pf cleared", int'(status_byte[0]), 0);
    check("R10 clock no window", int'(busy), 0);

    do_wr(2, 0, 8'hF9); check("R9 control ack", int'(wr_ack), 1);
    check("R9 code bits", int'(prot_code), 1);
    check("R10 window open", int'(busy), 1);
    do_wr(0, 0, 8'h55); check("R10 reject in window", int'(wr_nack), 1);
    idle(NV + 2);
    do_wr(0, 383, 8'h01); check("R8 below range", int'(wr_ack), 1);
    idle(NV + 2);
    do_wr(0, 384, 8'h01); check("R8 range start", int'(wr_nack), 1);

    for (int c = 0; c < 8; c++) begin
      int none, lo, hi;
      do_wr(2, 0, c);
      idle(NV + 2);
      range_of(c, none, lo, hi);
      check("R7 code none", int'(prot_none), none);
      for (int i = 0; i < 11; i++) begin
        int exp_ok;
        exp_ok = int'(probes[i] < D && (none != 0 || probes[i] < lo || probes[i] > hi));
        do_wr(0, probes[i], 8'h5A);
        check("R8 probe", int'(wr_ack), exp_ok);
        idle(NV + 2);
      end
    end

    do_wr(3, 0, 8'h00); check("R3 clear pattern", int'(status_byte), 8'h00);
    do_wr(0, 0, 8'h00); check("R2 relocked", int'(wr_nack), 1);
    do_wr(3, 0, 8'h02);
    do_wr(1, 0, 8'h00); check("R10 status/clock ready", int'(busy), 0);

    pulse_reset(1'b0);
    check("R1 warm status", int'(status_byte), 8'h00);
    check("R1 warm code kept", int'(prot_code), 7);
    check("R1 warm clk_run", int'(clk_run), 1);

    pulse_reset(1'b1);
    check("R1 cold again status", int'(status_byte), 8'h01);
    check("R1 cold again code", int'(prot_code), 0);
    check("R1 cold again clk_run", int'(clk_run), 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule